// File: doc/BRIEF.md
# Wake Source Flag Register

This block records why a low-power controller left its sleep or display-only state, and which kind of reset happened last. Six external pins are brought through a synchronizer and watched for a high level, a rising edge or any edge, depending on the source. An internal wake-timer expiry strobe and six reset-cause strobes (reset pin, software reset bit, debug-port reset, watchdog overflow, cold start, bad supply) are already synchronous and are taken directly. Each source owns one sticky flag, and the processor reads the whole set as one vector.

All flags drop together when the internal wake signal goes from high to low, which happens as the controller enters a low-power mode, so software never has to clear them. Among the reset-cause flags, a fixed clearing matrix applies: when certain cause flags set, certain other cause flags are cleared. One flag can be moved between two sources by an option input: it either watches a high level on a general pin or any edge on an optical receive pin.

Top module: `wake_flag_reg`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, all twelve bits of flags are 0.
- R2: A one-cycle high on tmr_expire sets flags[0] at the next rising clock edge.
- R3: A high level on pb_pin sets flags[1] and a high level on gpio_lvl_pin sets flags[4]; the flag becomes visible three rising edges after the pin changes (two synchronizer stages plus the flag register) and not earlier.
- R4: flags[3] sets on a low-to-high change of gpio_rise_pin; a high-to-low change of that pin leaves flags[3] at 0.
- R5: flags[2] sets on any change of rx_pin, rising or falling.
- R6: With opt_level_sel = 1, flags[5] sets on a high level of gpio_opt_pin and opt_rx_pin has no effect on it; with opt_level_sel = 0, flags[5] sets on any change of opt_rx_pin and gpio_opt_pin has no effect on it.
- R7: A cycle in which wake_int is low after being high in the previous cycle clears all flags at that edge, even if a set event for any flag arrives in the same cycle.
- R8: A flag, once set, holds its value until a clear defined in R7 or R10 occurs.
- R9: The reset-cause strobes set flags[6] (rst_pin_evt), flags[7] (sw_rst_evt), flags[8] (dbg_rst_evt), flags[9] (wdog_ovf_evt), flags[10] (cold_start_evt) and flags[11] (bad_supply_evt) at the next edge; flags[8] sets only if dbg_en is high in the same cycle as dbg_rst_evt.
- R10: Setting of cause flags clears others: flags[6] by cold start, software, watchdog or bad supply; flags[7] by cold start, watchdog, bad supply or reset pin; flags[8] by cold start, reset pin, watchdog or software; flags[9] by cold start, software, bad supply or reset pin; flags[10] by software, watchdog, bad supply or reset pin; flags[11] only by the R7 clear.
- R11: When a set event and a matrix clear for the same flag arrive in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_int | input | 1 | Internal wake signal; its falling transition clears all flags |
| tmr_expire | input | 1 | Wake-timer expiry strobe (synchronous) |
| pb_pin | input | 1 | Push-button pin, level source |
| rx_pin | input | 1 | Serial receive pin, either-edge source |
| gpio_rise_pin | input | 1 | General pin, rising-edge source |
| gpio_lvl_pin | input | 1 | General pin, level source |
| gpio_opt_pin | input | 1 | General pin, level source when opt_level_sel is 1 |
| opt_rx_pin | input | 1 | Optical receive pin, either-edge source when opt_level_sel is 0 |
| opt_level_sel | input | 1 | Selects the source of flags[5] (quasi-static) |
| rst_pin_evt | input | 1 | Reset-pin cause strobe |
| sw_rst_evt | input | 1 | Software reset cause strobe |
| dbg_rst_evt | input | 1 | Debug-port reset cause strobe |
| dbg_en | input | 1 | Debug enable; gates dbg_rst_evt |
| wdog_ovf_evt | input | 1 | Watchdog overflow cause strobe |
| cold_start_evt | input | 1 | Cold-start cause strobe |
| bad_supply_evt | input | 1 | Bad-supply cause strobe |
| flags | output | 12 | Sticky flags, bit positions as in R2 to R9 |

## Verification
Two pairs of functions can land in one cycle: the wake-fall clear against any set event, and a cause flag's own set against a matrix clear from another cause. The bench drives a timer strobe in the very cycle wake_int drops and expects an all-zero vector, and drives two mutually clearing cause strobes together and expects both flags set. A long random phase then mixes pin toggles, strobes and short wake drops so that these collisions recur, and a behavioural model built from pin-sample history judges every cycle.

// File: rtl/wake_flag_pkg.sv
// Shared constants for the wake source flag register.
// Assumes the pin order and flag positions listed below are fixed by the
// register's software view.
package wake_flag_pkg;

    // Synchronized pin indices
    localparam int PIN_PB    = 0;
    localparam int PIN_RX    = 1;
    localparam int PIN_GRISE = 2;
    localparam int PIN_GLVL  = 3;
    localparam int PIN_GOPT  = 4;
    localparam int PIN_ORX   = 5;
    localparam int NUM_PINS  = 6;

    // Flag groups: wake flags occupy the low bits, cause flags follow
    localparam int NUM_WAKE  = 6;
    localparam int NUM_CAUSE = 6;
    localparam int NUM_FLAGS = NUM_WAKE + NUM_CAUSE;

    // Cause indices within the cause group
    localparam int CAUSE_PIN  = 0;
    localparam int CAUSE_SW   = 1;
    localparam int CAUSE_DBG  = 2;
    localparam int CAUSE_WDOG = 3;
    localparam int CAUSE_COLD = 4;
    localparam int CAUSE_BAD  = 5;

    typedef enum logic [1:0] {
        DET_LEVEL = 2'd0,
        DET_RISE  = 2'd1,
        DET_BOTH  = 2'd2
    } det_kind_e;

    // Detection type per synchronized pin
    function automatic det_kind_e pin_kind(input int idx);
        case (idx)
            PIN_RX, PIN_ORX: return DET_BOTH;
            PIN_GRISE:       return DET_RISE;
            default:         return DET_LEVEL;
        endcase
    endfunction

    // Which cause set events clear cause flag c
    function automatic logic [NUM_CAUSE-1:0] cause_clear_mask(input int c);
        logic [NUM_CAUSE-1:0] m;
        m = '0;
        case (c)
            CAUSE_PIN: begin
                m[CAUSE_COLD] = 1'b1; m[CAUSE_SW] = 1'b1;
                m[CAUSE_WDOG] = 1'b1; m[CAUSE_BAD] = 1'b1;
            end
            CAUSE_SW: begin
                m[CAUSE_COLD] = 1'b1; m[CAUSE_WDOG] = 1'b1;
                m[CAUSE_BAD]  = 1'b1; m[CAUSE_PIN]  = 1'b1;
            end
            CAUSE_DBG: begin
                m[CAUSE_COLD] = 1'b1; m[CAUSE_PIN] = 1'b1;
                m[CAUSE_WDOG] = 1'b1; m[CAUSE_SW]  = 1'b1;
            end
            CAUSE_WDOG: begin
                m[CAUSE_COLD] = 1'b1; m[CAUSE_SW]  = 1'b1;
                m[CAUSE_BAD]  = 1'b1; m[CAUSE_PIN] = 1'b1;
            end
            CAUSE_COLD: begin
                m[CAUSE_SW]  = 1'b1; m[CAUSE_WDOG] = 1'b1;
                m[CAUSE_BAD] = 1'b1; m[CAUSE_PIN]  = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wake_pin_sync.sv
// Multi-stage synchronizer for asynchronous wake pins, with one extra
// register holding the previous synchronized value for edge compares.
// Assumes STAGES >= 2 and pins slower than the clock.
module wake_pin_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    // Shift pins through the synchronizer chain and keep one older sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            prev_q <= '0;
        end else begin
            chain_q[0] <= pins;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign cur  = chain_q[STAGES-1];
    assign prev = prev_q;

endmodule

// File: rtl/wake_edge_detect.sv
// Per-pin event detector. KIND picks level, rising-edge or any-edge
// detection on a synchronized value and its one-cycle-older copy.
// Assumes both inputs come from the same synchronizer.
module wake_edge_detect
    import wake_flag_pkg::*;
#(
    parameter det_kind_e KIND = DET_LEVEL
) (
    input  logic cur,
    input  logic prev,
    output logic hit
);

    // Select the detection rule fixed by KIND
    always_comb begin
        case (KIND)
            DET_RISE: hit = cur & ~prev;
            DET_BOTH: hit = cur ^ prev;
            default:  hit = cur;
        endcase
    end

endmodule

// File: rtl/wake_flag_bank.sv
// Sticky flag storage. Wake flags set on their events; cause flags set on
// their strobes and are cleared by the cause matrix. A falling wake_int
// clears everything and outranks every set; a set outranks a matrix clear.
// Assumes wake_int is synchronous to clk.
module wake_flag_bank
    import wake_flag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wake_int,
    input  logic [NUM_WAKE-1:0]  wake_set,
    input  logic [NUM_CAUSE-1:0] cause_set,
    output logic [NUM_FLAGS-1:0] flags
);

    logic                 wake_q;
    logic                 wake_fall;
    logic [NUM_WAKE-1:0]  wake_flag_q;
    logic [NUM_CAUSE-1:0] cause_flag_q;

    // Remember last wake_int to find its high-to-low transition
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_int;
    end

    assign wake_fall = wake_q & ~wake_int;

    // Wake flags: set on event, cleared only by the wake fall
    always_ff @(posedge clk) begin
        if (!rst_n || wake_fall) wake_flag_q <= '0;
        else                     wake_flag_q <= wake_flag_q | wake_set;
    end

    // Cause flags: one register per cause with its own clear mask
    for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
        localparam logic [NUM_CAUSE-1:0] MASK = cause_clear_mask(g);
        logic matrix_clr;

        assign matrix_clr = |(cause_set & MASK);

        // Priority: reset, wake fall, own set, matrix clear, hold
        always_ff @(posedge clk) begin
            if (!rst_n || wake_fall) cause_flag_q[g] <= 1'b0;
            else if (cause_set[g])   cause_flag_q[g] <= 1'b1;
            else if (matrix_clr)     cause_flag_q[g] <= 1'b0;
        end
    end

    assign flags = {cause_flag_q, wake_flag_q};

endmodule

// File: rtl/wake_flag_reg.sv
// Wake source flag register top. Synchronizes the wake pins, detects
// events per pin, steers the optional source, gates the debug reset with
// its enable and stores everything in the sticky flag bank.
// Assumes reset-cause strobes, tmr_expire and wake_int are synchronous,
// and opt_level_sel changes only while its sources are idle.
module wake_flag_reg
    import wake_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wake_int,
    input  logic                 tmr_expire,
    input  logic                 pb_pin,
    input  logic                 rx_pin,
    input  logic                 gpio_rise_pin,
    input  logic                 gpio_lvl_pin,
    input  logic                 gpio_opt_pin,
    input  logic                 opt_rx_pin,
    input  logic                 opt_level_sel,
    input  logic                 rst_pin_evt,
    input  logic                 sw_rst_evt,
    input  logic                 dbg_rst_evt,
    input  logic                 dbg_en,
    input  logic                 wdog_ovf_evt,
    input  logic                 cold_start_evt,
    input  logic                 bad_supply_evt,
    output logic [NUM_FLAGS-1:0] flags
);

    logic [NUM_PINS-1:0]  raw_pins;
    logic [NUM_PINS-1:0]  sync_cur;
    logic [NUM_PINS-1:0]  sync_prev;
    logic [NUM_PINS-1:0]  pin_hit;
    logic [NUM_WAKE-1:0]  wake_set;
    logic [NUM_CAUSE-1:0] cause_set;

    // Gather pins in package index order
    always_comb begin
        raw_pins            = '0;
        raw_pins[PIN_PB]    = pb_pin;
        raw_pins[PIN_RX]    = rx_pin;
        raw_pins[PIN_GRISE] = gpio_rise_pin;
        raw_pins[PIN_GLVL]  = gpio_lvl_pin;
        raw_pins[PIN_GOPT]  = gpio_opt_pin;
        raw_pins[PIN_ORX]   = opt_rx_pin;
    end

    wake_pin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (raw_pins),
        .cur   (sync_cur),
        .prev  (sync_prev)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_det
        wake_edge_detect #(
            .KIND (pin_kind(p))
        ) det_i (
            .cur  (sync_cur[p]),
            .prev (sync_prev[p]),
            .hit  (pin_hit[p])
        );
    end

    // Map detected events onto wake flag positions
    always_comb begin
        wake_set    = '0;
        wake_set[0] = tmr_expire;
        wake_set[1] = pin_hit[PIN_PB];
        wake_set[2] = pin_hit[PIN_RX];
        wake_set[3] = pin_hit[PIN_GRISE];
        wake_set[4] = pin_hit[PIN_GLVL];
        wake_set[5] = opt_level_sel ? pin_hit[PIN_GOPT] : pin_hit[PIN_ORX];
    end

    // Map reset-cause strobes onto cause indices
    always_comb begin
        cause_set             = '0;
        cause_set[CAUSE_PIN]  = rst_pin_evt;
        cause_set[CAUSE_SW]   = sw_rst_evt;
        cause_set[CAUSE_DBG]  = dbg_rst_evt & dbg_en;
        cause_set[CAUSE_WDOG] = wdog_ovf_evt;
        cause_set[CAUSE_COLD] = cold_start_evt;
        cause_set[CAUSE_BAD]  = bad_supply_evt;
    end

    wake_flag_bank bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_int  (wake_int),
        .wake_set  (wake_set),
        .cause_set (cause_set),
        .flags     (flags)
    );

endmodule

// File: rtl/wake_flag_reg_chk.sv
// Property checker for wake_flag_reg, attached by bind. Observes ports only
// and keeps its own copy of the previous wake_int sample.
module wake_flag_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wake_int,
    input logic        tmr_expire,
    input logic        rst_pin_evt,
    input logic        sw_rst_evt,
    input logic        dbg_rst_evt,
    input logic        dbg_en,
    input logic        wdog_ovf_evt,
    input logic        cold_start_evt,
    input logic        bad_supply_evt,
    input logic [11:0] flags
);

    logic seen_wake_q;
    logic drop;

    // Track wake_int one cycle back, independent of the design
    always_ff @(posedge clk) begin
        if (!rst_n) seen_wake_q <= 1'b0;
        else        seen_wake_q <= wake_int;
    end

    assign drop = seen_wake_q && !wake_int;

    assert_wake_drop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (flags == 12'h000));

    assert_timer_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expire && !drop) |=> flags[0]);

    assert_dbg_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[8] && !dbg_en) |=> !flags[8]);

    assert_sw_matrix_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst_evt && !rst_pin_evt && !dbg_rst_evt && !wdog_ovf_evt &&
         !cold_start_evt && !drop)
        |=> (flags[7] && !flags[6] && !flags[8] && !flags[9] && !flags[10]));

    assert_bad_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[11] && !drop) |=> flags[11]);

    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst_evt && wdog_ovf_evt && !drop) |=> (flags[7] && flags[9]));

endmodule

bind wake_flag_reg wake_flag_reg_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wake_int       (wake_int),
    .tmr_expire     (tmr_expire),
    .rst_pin_evt    (rst_pin_evt),
    .sw_rst_evt     (sw_rst_evt),
    .dbg_rst_evt    (dbg_rst_evt),
    .dbg_en         (dbg_en),
    .wdog_ovf_evt   (wdog_ovf_evt),
    .cold_start_evt (cold_start_evt),
    .bad_supply_evt (bad_supply_evt),
    .flags          (flags)
);

// File: tb/wake_flag_reg_tb_top.sv
`timescale 1ns/100ps
// Bench: directed scenarios plus a random phase, all compared every cycle
// against a behavioural model built on a queue of pin samples.
module wake_flag_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wake_int = 1'b1;
    logic        tmr_expire = 1'b0;
    logic        pb_pin = 1'b0, rx_pin = 1'b0, gpio_rise_pin = 1'b0;
    logic        gpio_lvl_pin = 1'b0, gpio_opt_pin = 1'b0, opt_rx_pin = 1'b0;
    logic        opt_level_sel = 1'b0;
    logic        rst_pin_evt = 1'b0, sw_rst_evt = 1'b0, dbg_rst_evt = 1'b0;
    logic        dbg_en = 1'b0, wdog_ovf_evt = 1'b0, cold_start_evt = 1'b0;
    logic        bad_supply_evt = 1'b0;
    logic [11:0] flags;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wake_flag_reg dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wake_int       (wake_int),
        .tmr_expire     (tmr_expire),
        .pb_pin         (pb_pin),
        .rx_pin         (rx_pin),
        .gpio_rise_pin  (gpio_rise_pin),
        .gpio_lvl_pin   (gpio_lvl_pin),
        .gpio_opt_pin   (gpio_opt_pin),
        .opt_rx_pin     (opt_rx_pin),
        .opt_level_sel  (opt_level_sel),
        .rst_pin_evt    (rst_pin_evt),
        .sw_rst_evt     (sw_rst_evt),
        .dbg_rst_evt    (dbg_rst_evt),
        .dbg_en         (dbg_en),
        .wdog_ovf_evt   (wdog_ovf_evt),
        .cold_start_evt (cold_start_evt),
        .bad_supply_evt (bad_supply_evt),
        .flags          (flags)
    );

    // ---------------- reference model ----------------
    logic [5:0]  hist [$];
    logic [11:0] exp_flags = 12'h000;
    bit          wake_was = 1'b0;

    always @(posedge clk) begin : model
        logic [5:0]  older, oldest;
        logic        pb_e, rx_e, gr_e, gl_e, go_e, or_e;
        logic [11:0] nf;
        if (!rst_n) begin
            hist.delete();
            repeat (3) hist.push_back(6'd0);
            exp_flags = 12'h000;
            wake_was  = 1'b0;
        end else begin
            older  = hist[1];   // pins two edges back
            oldest = hist[0];   // pins three edges back
            pb_e = older[0];
            rx_e = older[1] != oldest[1];
            gr_e = older[2] && !oldest[2];
            gl_e = older[3];
            go_e = older[4];
            or_e = older[5] != oldest[5];
            if (wake_was && !wake_int) begin
                nf = 12'h000;
            end else begin
                nf = exp_flags;
                if (tmr_expire) nf[0] = 1'b1;
                if (pb_e) nf[1] = 1'b1;
                if (rx_e) nf[2] = 1'b1;
                if (gr_e) nf[3] = 1'b1;
                if (gl_e) nf[4] = 1'b1;
                if (opt_level_sel ? go_e : or_e) nf[5] = 1'b1;
                // matrix clears first, then own sets override them
                if (cold_start_evt || sw_rst_evt || wdog_ovf_evt || bad_supply_evt) nf[6] = 1'b0;
                if (cold_start_evt || wdog_ovf_evt || bad_supply_evt || rst_pin_evt) nf[7] = 1'b0;
                if (cold_start_evt || rst_pin_evt || wdog_ovf_evt || sw_rst_evt) nf[8] = 1'b0;
                if (cold_start_evt || sw_rst_evt || bad_supply_evt || rst_pin_evt) nf[9] = 1'b0;
                if (sw_rst_evt || wdog_ovf_evt || bad_supply_evt || rst_pin_evt) nf[10] = 1'b0;
                if (rst_pin_evt) nf[6] = 1'b1;
                if (sw_rst_evt) nf[7] = 1'b1;
                if (dbg_rst_evt && dbg_en) nf[8] = 1'b1;
                if (wdog_ovf_evt) nf[9] = 1'b1;
                if (cold_start_evt) nf[10] = 1'b1;
                if (bad_supply_evt) nf[11] = 1'b1;
            end
            exp_flags = nf;
            hist.push_back({opt_rx_pin, gpio_opt_pin, gpio_lvl_pin,
                            gpio_rise_pin, rx_pin, pb_pin});
            void'(hist.pop_front());
            wake_was = wake_int;
        end
    end

    function automatic string req_of(input logic [11:0] diff);
        for (int b = 0; b < 12; b++) begin
            if (diff[b]) begin
                case (b)
                    0:       return "R2";
                    1, 4:    return "R3";
                    2:       return "R5";
                    3:       return "R4";
                    5:       return "R6";
                    default: return "R10";
                endcase
            end
        end
        return "R8";
    endfunction

    // Per-cycle model comparison, sampled mid-cycle
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (flags !== exp_flags) begin
                fails++;
                $display("FAIL %s model compare: act %h exp %h",
                         req_of(flags ^ exp_flags), flags, exp_flags);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [11:0] exp);
        checks++;
        if (flags !== exp) begin
            fails++;
            $display("FAIL %s directed: act %h exp %h", tag, flags, exp);
        end
    endtask

    task automatic wake_clear();
        wake_int = 1'b0;
        tick(1);
        chk("R7", 12'h000);
        wake_int = 1'b1;
        tick(1);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        tick(4);
        chk("R1", 12'h000);
        rst_n = 1'b1;
        tick(1);
        chk("R1", 12'h000);

        // R2 timer strobe, then R8 hold, then R7 clear
        tmr_expire = 1'b1; tick(1); tmr_expire = 1'b0;
        chk("R2", 12'h001);
        tick(3);
        chk("R8", 12'h001);
        wake_clear();

        // R3 level sources with latency
        pb_pin = 1'b1; tick(2);
        chk("R3", 12'h000);
        tick(1);
        chk("R3", 12'h002);
        pb_pin = 1'b0; tick(5);
        chk("R8", 12'h002);
        wake_clear();
        gpio_lvl_pin = 1'b1; tick(3);
        chk("R3", 12'h010);
        gpio_lvl_pin = 1'b0; tick(4);
        wake_clear();

        // R4 rising edge only
        gpio_rise_pin = 1'b1; tick(3);
        chk("R4", 12'h008);
        tick(2);
        wake_clear();
        gpio_rise_pin = 1'b0; tick(5);
        chk("R4", 12'h000);

        // R5 either edge
        rx_pin = 1'b1; tick(3);
        chk("R5", 12'h004);
        wake_clear();
        rx_pin = 1'b0; tick(3);
        chk("R5", 12'h004);
        wake_clear();

        // R6 option select
        opt_level_sel = 1'b1;
        opt_rx_pin = 1'b1; tick(5);
        chk("R6", 12'h000);
        gpio_opt_pin = 1'b1; tick(3);
        chk("R6", 12'h020);
        gpio_opt_pin = 1'b0; tick(4);
        wake_clear();
        opt_level_sel = 1'b0;
        gpio_opt_pin = 1'b1; tick(5);
        chk("R6", 12'h000);
        opt_rx_pin = 1'b0; tick(3);
        chk("R6", 12'h020);
        gpio_opt_pin = 1'b0; tick(4);
        wake_clear();

        // R9 / R10 cause flags and matrix
        rst_pin_evt = 1'b1; tick(1); rst_pin_evt = 1'b0;
        chk("R9", 12'h040);
        bad_supply_evt = 1'b1; tick(1); bad_supply_evt = 1'b0;
        chk("R10", 12'h800);
        dbg_rst_evt = 1'b1; tick(1); dbg_rst_evt = 1'b0;
        chk("R9", 12'h800);
        dbg_en = 1'b1;
        dbg_rst_evt = 1'b1; tick(1); dbg_rst_evt = 1'b0;
        chk("R9", 12'h900);
        sw_rst_evt = 1'b1; tick(1); sw_rst_evt = 1'b0;
        chk("R10", 12'h880);
        wdog_ovf_evt = 1'b1; tick(1); wdog_ovf_evt = 1'b0;
        chk("R10", 12'hA00);
        cold_start_evt = 1'b1; tick(1); cold_start_evt = 1'b0;
        chk("R10", 12'hC00);
        rst_pin_evt = 1'b1; tick(1); rst_pin_evt = 1'b0;
        chk("R10", 12'h840);
        dbg_rst_evt = 1'b1; tick(1); dbg_rst_evt = 1'b0;
        chk("R9", 12'h940);
        cold_start_evt = 1'b1; tick(1); cold_start_evt = 1'b0;
        chk("R10", 12'hC00);

        // R11 simultaneous sets that clear each other
        sw_rst_evt = 1'b1; wdog_ovf_evt = 1'b1; tick(1);
        sw_rst_evt = 1'b0; wdog_ovf_evt = 1'b0;
        chk("R11", 12'hA80);
        rst_pin_evt = 1'b1; sw_rst_evt = 1'b1; tick(1);
        rst_pin_evt = 1'b0; sw_rst_evt = 1'b0;
        chk("R11", 12'h8C0);

        // R7 wake fall beats a same-cycle set
        wake_int = 1'b0; tmr_expire = 1'b1; bad_supply_evt = 1'b1; tick(1);
        tmr_expire = 1'b0; bad_supply_evt = 1'b0;
        chk("R7", 12'h000);
        wake_int = 1'b1; tick(1);

        // Random phase, judged by the model on every cycle (R2..R11)
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0)  pb_pin        = ~pb_pin;
            if ($urandom_range(7) == 0)  rx_pin        = ~rx_pin;
            if ($urandom_range(7) == 0)  gpio_rise_pin = ~gpio_rise_pin;
            if ($urandom_range(7) == 0)  gpio_lvl_pin  = ~gpio_lvl_pin;
            if ($urandom_range(7) == 0)  gpio_opt_pin  = ~gpio_opt_pin;
            if ($urandom_range(7) == 0)  opt_rx_pin    = ~opt_rx_pin;
            if ($urandom_range(199) == 0) opt_level_sel = ~opt_level_sel;
            if ($urandom_range(31) == 0) dbg_en        = ~dbg_en;
            tmr_expire     = ($urandom_range(15) == 0);
            rst_pin_evt    = ($urandom_range(11) == 0);
            sw_rst_evt     = ($urandom_range(11) == 0);
            dbg_rst_evt    = ($urandom_range(11) == 0);
            wdog_ovf_evt   = ($urandom_range(11) == 0);
            cold_start_evt = ($urandom_range(11) == 0);
            bad_supply_evt = ($urandom_range(23) == 0);
            wake_int       = ($urandom_range(39) != 0);
            tick(1);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog: act running exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule